// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block produces the active-low read and write strobes for parallel ATA programmed-I/O and multiword DMA cycles. A single 32-bit timing word describes two independent sets of phase lengths. One set is for data-port accesses and the other is for task-file register accesses. Each field counts bus-clock cycles as its value plus one. The word is loaded through a configuration write. On every load, the FIFO-enable bit is replaced by the mode flag given with the write.

A transfer request carries an access kind and a direction. The first transfer out of idle runs a setup phase with both strobes high. It then drives the selected strobe low for the active phase and high again for the recovery phase. A one-cycle done pulse marks the last recovery cycle. A request that is present during that done cycle chains straight into the next active phase without a new setup. Every transfer works from a private copy of the timing word taken when it starts. A configuration write during a transfer therefore affects only the following transfers.

Top module: `ata_pio_strobe`

## Requirements
- R1: A synchronous active-high reset, even one that arrives mid-transfer, brings the block back to idle in the next cycle. After it, both strobes are high, busy and done are low, and the stored timing word is zero.
- R2: A configuration write stores the input word with bit 31 (FIFO enable) forced to the mode flag: 0 for PIO and 1 for DMA. The mode bits 30:28 and all timing fields are stored unchanged, and the stored word is visible on `cfgOut` the cycle after the write.
- R3: For a data access started from idle, the timing fields are read as follows. The setup phase lasts bits 24:22 plus one cycles. The strobe stays low for bits 8:4 plus one cycles. The recovery phase lasts bits 3:0 plus one cycles.
- R4: For a task-file access started from idle, the timing fields are read as follows. The setup phase lasts bits 27:25 plus one cycles. The strobe stays low for bits 17:13 plus one cycles. The recovery phase lasts bits 12:9 plus one cycles.
- R5: A write request (`reqWrite`=1) lowers only `wrStrobeN`, and a read request lowers only `rdStrobeN`. The two strobes are never low together, and both are high outside the active phase.
- R6: `busy` is high from the cycle after a request is accepted through the last recovery cycle. `done` is high for exactly that last recovery cycle.
- R7: A request held during the done cycle is accepted at once. Its strobe goes low in the very next cycle, with no setup phase, and it uses its own direction, kind and the current timing word.
- R8: The timing word and request attributes are captured when a transfer is accepted. A configuration write during a transfer leaves that transfer's phase lengths unchanged and applies to the next one.
- R9: A request raised while busy, outside the done cycle, is ignored. The running transfer keeps its lengths, and the block goes idle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgWrEn | input | 1 | Load the timing word this cycle |
| cfgIsDma | input | 1 | Mode of the word being loaded; sets the FIFO-enable bit |
| cfgWord | input | 32 | Timing word to load |
| reqValid | input | 1 | Transfer request; accepted when idle or in the done cycle |
| reqTaskFile | input | 1 | 1 selects task-file timing, 0 selects data timing |
| reqWrite | input | 1 | 1 for a write strobe, 0 for a read strobe |
| rdStrobeN | output | 1 | Active-low read strobe |
| wrStrobeN | output | 1 | Active-low write strobe |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | Last recovery cycle of a transfer |
| cfgOut | output | 32 | Stored timing word after FIFO-bit forcing |

## Verification
The hardest situations to reach from the ports involve requests that overlap a running transfer. A configuration write can land inside the setup phase of a transfer already under way. A request can arrive exactly in the done cycle. A stray request can appear in the middle of the active phase. The bench reaches each of these by forking a second stimulus thread next to the phase monitor and timing its changes in whole clock cycles from the accept edge. The monitor then measures the setup, low and recovery lengths that resulted. Field values at zero and at their maxima, placed in both the data and task-file slots, cover the extremes of each phase counter.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  localparam int WORD_W   = 32;

  // field layout of the timing word (decoded by the phase counter)
  localparam int HI_W     = 4;
  localparam int LO_W     = 5;
  localparam int PRE_W    = 3;
  localparam int DAT_HI_L = 0;
  localparam int DAT_LO_L = 4;
  localparam int TF_HI_L  = 9;
  localparam int TF_LO_L  = 13;
  localparam int DAT_PRE_L = 22;
  localparam int TF_PRE_L  = 25;
  localparam int FIFO_BIT  = 31;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_ACTIVE  = 2'd2,
    PH_RECOVER = 2'd3
  } phase_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic capture;
    logic loadSetup;
    logic loadActive;
    logic loadRecover;
  } dpCtrl_t;
endpackage

// File: rtl/ata_pio_dp.sv
module ata_pio_dp
  import ata_pio_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWrEn,
  input  logic              cfgIsDma,
  input  logic [WORD_W-1:0] cfgWord,
  input  logic              reqTaskFile,
  input  logic              reqWrite,
  input  dpCtrl_t           ctl,
  output logic              cntZero,
  output logic              xferWrite,
  output logic [WORD_W-1:0] cfgOut
);
  localparam logic [WORD_W-1:0] FIFO_MASK = WORD_W'(1) << FIFO_BIT;
  localparam int NKIND = 2;

  logic [WORD_W-1:0] cfgReg;
  logic [WORD_W-1:0] snapWord;
  logic              snapTask;
  logic              snapWrite;
  logic [CNT_W-1:0]  cnt;

  logic [WORD_W-1:0] srcWord;
  logic              srcTask;
  logic [CNT_W-1:0]  preVal [NKIND];
  logic [CNT_W-1:0]  loVal  [NKIND];
  logic [CNT_W-1:0]  hiVal  [NKIND];
  logic [CNT_W-1:0]  preSel, loSel, hiSel;

  // stored timing word, FIFO bit follows the mode of the load
  always_ff @(posedge clk) begin
    if (rst)
      cfgReg <= '0;
    else if (cfgWrEn)
      cfgReg <= (cfgWord & ~FIFO_MASK) | (cfgIsDma ? FIFO_MASK : '0);
  end

  // per-transfer snapshot
  always_ff @(posedge clk) begin
    if (rst) begin
      snapWord  <= '0;
      snapTask  <= 1'b0;
      snapWrite <= 1'b0;
    end else if (ctl.capture) begin
      snapWord  <= cfgReg;
      snapTask  <= reqTaskFile;
      snapWrite <= reqWrite;
    end
  end

  assign srcWord = ctl.capture ? cfgReg : snapWord;
  assign srcTask = ctl.capture ? reqTaskFile : snapTask;

  // field decode for the two access kinds: 0 = data, 1 = task file
  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    localparam int PRE_L = (k == 0) ? DAT_PRE_L : TF_PRE_L;
    localparam int LO_L  = (k == 0) ? DAT_LO_L  : TF_LO_L;
    localparam int HI_L  = (k == 0) ? DAT_HI_L  : TF_HI_L;
    assign preVal[k] = CNT_W'(srcWord[PRE_L +: PRE_W]);
    assign loVal[k]  = CNT_W'(srcWord[LO_L  +: LO_W]);
    assign hiVal[k]  = CNT_W'(srcWord[HI_L  +: HI_W]);
  end

  assign preSel = preVal[srcTask];
  assign loSel  = loVal[srcTask];
  assign hiSel  = hiVal[srcTask];

  // phase counter: loaded with field value, runs down to zero
  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (ctl.loadSetup)
      cnt <= preSel;
    else if (ctl.loadActive)
      cnt <= loSel;
    else if (ctl.loadRecover)
      cnt <= hiSel;
    else if (cnt != '0)
      cnt <= cnt - CNT_W'(1);
  end

  assign cntZero   = (cnt == '0);
  assign xferWrite = snapWrite;
  assign cfgOut    = cfgReg;
endmodule

// File: rtl/ata_pio_ctrl.sv
module ata_pio_ctrl
  import ata_pio_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  input  logic    cntZero,
  input  logic    xferWrite,
  output dpCtrl_t ctl,
  output logic    rdStrobeN,
  output logic    wrStrobeN,
  output logic    busy,
  output logic    done
);
  phase_t phase, phaseNext;

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    ctl       = '0;
    unique case (phase)
      PH_IDLE: begin
        if (reqValid) begin
          ctl.capture   = 1'b1;
          ctl.loadSetup = 1'b1;
          phaseNext     = PH_SETUP;
        end
      end
      PH_SETUP: begin
        if (cntZero) begin
          ctl.loadActive = 1'b1;
          phaseNext      = PH_ACTIVE;
        end
      end
      PH_ACTIVE: begin
        if (cntZero) begin
          ctl.loadRecover = 1'b1;
          phaseNext       = PH_RECOVER;
        end
      end
      PH_RECOVER: begin
        if (cntZero) begin
          if (reqValid) begin
            ctl.capture    = 1'b1;
            ctl.loadActive = 1'b1;
            phaseNext      = PH_ACTIVE;
          end else begin
            phaseNext = PH_IDLE;
          end
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  assign rdStrobeN = !((phase == PH_ACTIVE) && !xferWrite);
  assign wrStrobeN = !((phase == PH_ACTIVE) &&  xferWrite);
  assign busy      = (phase != PH_IDLE);
  assign done      = (phase == PH_RECOVER) && cntZero;
endmodule

// File: rtl/ata_pio_strobe.sv
module ata_pio_strobe #(
  parameter int CNT_W = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfgWrEn,
  input  logic        cfgIsDma,
  input  logic [31:0] cfgWord,
  input  logic        reqValid,
  input  logic        reqTaskFile,
  input  logic        reqWrite,
  output logic        rdStrobeN,
  output logic        wrStrobeN,
  output logic        busy,
  output logic        done,
  output logic [31:0] cfgOut
);
  import ata_pio_pkg::*;

  dpCtrl_t ctl;
  logic    cntZero;
  logic    xferWrite;

  ata_pio_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .reqValid  (reqValid),
    .cntZero   (cntZero),
    .xferWrite (xferWrite),
    .ctl       (ctl),
    .rdStrobeN (rdStrobeN),
    .wrStrobeN (wrStrobeN),
    .busy      (busy),
    .done      (done)
  );

  ata_pio_dp #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .cfgWrEn     (cfgWrEn),
    .cfgIsDma    (cfgIsDma),
    .cfgWord     (cfgWord),
    .reqTaskFile (reqTaskFile),
    .reqWrite    (reqWrite),
    .ctl         (ctl),
    .cntZero     (cntZero),
    .xferWrite   (xferWrite),
    .cfgOut      (cfgOut)
  );
endmodule

// File: rtl/ata_pio_strobe_chk.sv
module ata_pio_strobe_chk (
  input logic        clk,
  input logic        rst,
  input logic        cfgWrEn,
  input logic        cfgIsDma,
  input logic        reqValid,
  input logic        rdStrobeN,
  input logic        wrStrobeN,
  input logic        busy,
  input logic        done,
  input logic [31:0] cfgOut
);
  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!rdStrobeN && !wrStrobeN));

  // R6
  done_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  // R3
  setup_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (rdStrobeN && wrStrobeN));

  // R7
  chain_low_chk: assert property (@(posedge clk) disable iff (rst)
    (done && reqValid) |=> (!rdStrobeN || !wrStrobeN));

  // R9
  idle_after_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !reqValid) |=> !busy);

  // R2
  fifo_force_chk: assert property (@(posedge clk) disable iff (rst)
    cfgWrEn |=> (cfgOut[31] == $past(cfgIsDma)));
endmodule

bind ata_pio_strobe ata_pio_strobe_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfgWrEn   (cfgWrEn),
  .cfgIsDma  (cfgIsDma),
  .reqValid  (reqValid),
  .rdStrobeN (rdStrobeN),
  .wrStrobeN (wrStrobeN),
  .busy      (busy),
  .done      (done),
  .cfgOut    (cfgOut)
);

// File: tb/ata_pio_strobe_test.sv
module ata_pio_strobe_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgWrEn = 1'b0;
  logic        cfgIsDma = 1'b0;
  logic [31:0] cfgWord = '0;
  logic        reqValid = 1'b0;
  logic        reqTaskFile = 1'b0;
  logic        reqWrite = 1'b0;
  logic        rdStrobeN, wrStrobeN, busy, done;
  logic [31:0] cfgOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  ata_pio_strobe uut (
    .clk(clk), .rst(rst), .cfgWrEn(cfgWrEn), .cfgIsDma(cfgIsDma),
    .cfgWord(cfgWord), .reqValid(reqValid), .reqTaskFile(reqTaskFile),
    .reqWrite(reqWrite), .rdStrobeN(rdStrobeN), .wrStrobeN(wrStrobeN),
    .busy(busy), .done(done), .cfgOut(cfgOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic       tf;
    logic       wr;
    logic       dma;
    logic [2:0] mode;
    logic [2:0] pre;
    logic [4:0] lo;
    logic [3:0] hi;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b0, 1'b0, 3'b100, 3'd0, 5'd0,  4'd0},
    '{1'b0, 1'b1, 1'b1, 3'b010, 3'd7, 5'd31, 4'd15},
    '{1'b1, 1'b0, 1'b0, 3'b001, 3'd3, 5'd5,  4'd2},
    '{1'b1, 1'b1, 1'b1, 3'b110, 3'd7, 5'd31, 4'd15},
    '{1'b0, 1'b0, 1'b1, 3'b011, 3'd1, 5'd12, 4'd6},
    '{1'b1, 1'b1, 1'b0, 3'b000, 3'd0, 5'd0,  4'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // fields of the selected kind take the given values; the other kind gets different ones
  function automatic logic [31:0] mkWord(input bit tf, input logic [2:0] pre,
      input logic [4:0] lo, input logic [3:0] hi, input logic [2:0] mode, input bit dma);
    logic [2:0]  p2;
    logic [4:0]  l2;
    logic [3:0]  h2;
    logic [31:0] w;
    p2 = pre + 3'd1;
    l2 = lo + 5'd3;
    h2 = hi + 4'd5;
    w = '0;
    w[21:18] = 4'hA;
    w[30:28] = mode;
    w[31]    = !dma;
    if (tf) begin
      w[27:25] = pre; w[17:13] = lo; w[12:9] = hi;
      w[24:22] = p2;  w[8:4]   = l2; w[3:0]  = h2;
    end else begin
      w[24:22] = pre; w[8:4]   = lo; w[3:0]  = hi;
      w[27:25] = p2;  w[17:13] = l2; w[12:9] = h2;
    end
    return w;
  endfunction

  // classify each cycle of a transfer, sampled at negedges
  task automatic watch(input bit expWrite, input bit stopAtDone, output int sN,
      output int aN, output int rN, output int bad, output bit doneLast);
    int guard;
    int doneR;
    int doneN;
    sN = 0; aN = 0; rN = 0; bad = 0; doneN = 0; doneR = -1; guard = 0;
    while (busy && guard < 400) begin
      if (!rdStrobeN && !wrStrobeN) bad++;
      if (expWrite ? !rdStrobeN : !wrStrobeN) bad++;
      if (expWrite ? !wrStrobeN : !rdStrobeN) aN++;
      else if (aN == 0) sN++;
      else rN++;
      guard++;
      if (done) begin
        doneN++;
        doneR = rN;
        if (stopAtDone) break;
      end
      @(negedge clk);
    end
    doneLast = (doneN == 1) && (doneR == rN);
  endtask

  task automatic loadCfg(input logic [31:0] w, input bit dma);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWord = w; cfgIsDma = dma;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic startReq(input bit tf, input bit wr);
    reqTaskFile = tf; reqWrite = wr; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int s, a, r, bad;
    bit dl;
    logic [31:0] w, expW;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(rdStrobeN && wrStrobeN, "R1 strobes high in reset", {rdStrobeN, wrStrobeN}, 3);
    check(!busy && !done, "R1 busy/done low in reset", {busy, done}, 0);
    check(cfgOut == 32'd0, "R1 stored word zero", cfgOut, 0);
    rst = 1'b0;

    // table walk
    for (int i = 0; i < 6; i++) begin
      w = mkWord(VECS[i].tf, VECS[i].pre, VECS[i].lo, VECS[i].hi, VECS[i].mode, VECS[i].dma);
      expW = (w & 32'h7FFF_FFFF) | {VECS[i].dma, 31'd0};
      loadCfg(w, VECS[i].dma);
      check(cfgOut == expW, "R2 stored word with forced FIFO bit", cfgOut, expW);
      startReq(VECS[i].tf, VECS[i].wr);
      watch(VECS[i].wr, 1'b0, s, a, r, bad, dl);
      check(s == VECS[i].pre + 1, VECS[i].tf ? "R4 setup length" : "R3 setup length", s, VECS[i].pre + 1);
      check(a == VECS[i].lo + 1, VECS[i].tf ? "R4 low length" : "R3 low length", a, VECS[i].lo + 1);
      check(r == VECS[i].hi + 1, VECS[i].tf ? "R4 recovery length" : "R3 recovery length", r, VECS[i].hi + 1);
      check(bad == 0, "R5 wrong strobe low", bad, 0);
      check(dl, "R6 single done in last recovery cycle", dl, 1);
      check(rdStrobeN && wrStrobeN && !busy, "R5 idle strobes high", {rdStrobeN, wrStrobeN, busy}, 6);
    end

    // R7 back-to-back: hold request through done, change direction for the second
    loadCfg(mkWord(1'b0, 3'd2, 5'd3, 4'd1, 3'd0, 1'b0), 1'b0);
    reqTaskFile = 1'b0; reqWrite = 1'b0; reqValid = 1'b1;
    @(negedge clk);
    watch(1'b0, 1'b1, s, a, r, bad, dl);
    check(s == 3 && a == 4 && r == 2, "R7 first transfer lengths", s*100 + a*10 + r, 342);
    check(done && reqValid, "R7 request held in done cycle", {done, reqValid}, 3);
    reqWrite = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    watch(1'b1, 1'b0, s, a, r, bad, dl);
    check(s == 0, "R7 chained transfer has no setup", s, 0);
    check(a == 4 && r == 2, "R7 chained transfer lengths", a*10 + r, 42);
    check(bad == 0, "R7 chained transfer uses write strobe", bad, 0);
    check(dl, "R6 chained done", dl, 1);

    // R8 config write during setup of a running transfer
    loadCfg(mkWord(1'b0, 3'd2, 5'd2, 4'd1, 3'd0, 1'b0), 1'b0);
    startReq(1'b0, 1'b0);
    fork
      watch(1'b0, 1'b0, s, a, r, bad, dl);
      begin
        @(negedge clk);
        cfgWrEn = 1'b1;
        cfgWord = mkWord(1'b0, 3'd1, 5'd6, 4'd3, 3'd0, 1'b0);
        cfgIsDma = 1'b0;
        @(negedge clk);
        cfgWrEn = 1'b0;
      end
    join
    check(s == 3 && a == 3 && r == 2, "R8 running transfer keeps old word", s*100 + a*10 + r, 332);
    @(negedge clk);
    startReq(1'b0, 1'b0);
    watch(1'b0, 1'b0, s, a, r, bad, dl);
    check(s == 2 && a == 7 && r == 4, "R8 next transfer uses new word", s*100 + a*10 + r, 274);

    // R9 request during the active phase is ignored
    loadCfg(mkWord(1'b0, 3'd0, 5'd4, 4'd2, 3'd0, 1'b0), 1'b0);
    startReq(1'b0, 1'b1);
    fork
      watch(1'b1, 1'b0, s, a, r, bad, dl);
      begin
        repeat (2) @(negedge clk);
        reqValid = 1'b1;
        @(negedge clk);
        reqValid = 1'b0;
      end
    join
    check(s == 1 && a == 5 && r == 3, "R9 lengths unchanged by stray request", s*100 + a*10 + r, 153);
    check(dl, "R9 done seen once", dl, 1);
    @(negedge clk);
    check(!busy && rdStrobeN && wrStrobeN, "R9 idle after done", {busy, rdStrobeN, wrStrobeN}, 3);

    // R1 reset in the middle of the active phase
    startReq(1'b0, 1'b0);
    repeat (2) @(negedge clk);
    check(!rdStrobeN, "R1 precondition strobe low", rdStrobeN, 0);
    rst = 1'b1;
    @(negedge clk);
    check(rdStrobeN && wrStrobeN, "R1 strobes high after reset", {rdStrobeN, wrStrobeN}, 3);
    check(!busy && !done, "R1 idle after reset", {busy, done}, 0);
    check(cfgOut == 32'd0, "R1 word cleared by reset", cfgOut, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule